// File: doc/BRIEF.md
# Dual-Port Peripheral Disable Register

This block holds the disable controls for an on-chip floppy controller, in two copies. A host bus and a management bus each have their own simple register port. Each port reaches its own copy: the management copy is decoded at offset 0x01 and the host copy at offset 0x22. The two copies are merged with OR. A device is therefore switched off when either side asks for it, and it runs only when both sides leave it enabled.

The management copy has a sticky lock bit. Once that bit is written as 1, the management copy can be read but not changed until a reset. The lock has no effect on the host copy. The block also produces the effective floppy write-protect signal. That signal merges the register overrides, the write-protect input from the drive, and a forced-protect option that only applies while a drive select is active.

Two reset inputs, power-on and bus reset, each clear both copies, including the lock.

Top module: `ddr_dual_disable`

## Requirements
- R1: After either reset, both copies read 0x00, `wp_out` is 0 while all drive inputs are 0, and `fdc_enable` follows `fdc_activate` from the clock edge after reset ends.
- R2: A management write to offset 0x01 stores bit 0 (write-protect override), bit 1 (lock) and bit 3 (floppy disable). A read at 0x01 returns them in the same bit positions. A management read at any other offset returns 0x00.
- R3: A host write to offset 0x22 stores bit 0 and bit 3 of the host copy. Bit 1 of the host copy always reads 0, and a host read at any other offset returns 0x00.
- R4: Bit 2 and bits 7:4 read as 0 on both ports and ignore writes.
- R5: While the management lock bit is 1, writes to offset 0x01 complete but leave the management copy unchanged, and reads still return its contents.
- R6: The management lock never blocks host writes to the host copy.
- R7: `fdc_enable` is a register that, on each clock edge, takes `fdc_activate` AND NOT (management bit 3 OR host bit 3). A write therefore shows on `fdc_enable` one clock edge after the register updates.
- R8: `wp_out` is the combinational OR of management bit 0, host bit 0, `drv_wp_in`, (`drv_sel[0]` AND `force_wp`) and (`drv_sel[1]` AND `force_wp`).
- R9: A low pulse on `por_n` or on `bus_rst_n` alone clears both copies and releases the lock, so the management copy is writable again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| bus_rst_n | input | 1 | Bus reset, active low, synchronous |
| h_wr_en | input | 1 | Host-side write strobe |
| h_addr | input | 8 | Host-side register offset |
| h_wdata | input | 8 | Host-side write data |
| h_rdata | output | 8 | Host-side read data (combinational) |
| m_wr_en | input | 1 | Management-side write strobe |
| m_addr | input | 8 | Management-side register offset |
| m_wdata | input | 8 | Management-side write data |
| m_rdata | output | 8 | Management-side read data (combinational) |
| fdc_activate | input | 1 | Floppy controller's own activate control |
| drv_wp_in | input | 1 | Write-protect sense from the drive, active high |
| drv_sel | input | 2 | Drive selects 0 and 1, active high |
| force_wp | input | 1 | Forced-protect option, active high |
| fdc_enable | output | 1 | Registered floppy controller enable |
| wp_out | output | 1 | Effective write protect |

## Verification
On every cycle the assertions check three things. A locked management copy holds steady and the lock stays set. Host writes land even while the management copy is locked. A disable in either copy, or any write-protect source, shows at the outputs. The bench scenarios cover the rest. They show the exact read-back values and the zero reads of reserved bits and foreign offsets. They show the one-cycle delay of `fdc_enable`, each of the write-protect terms in isolation, and that each reset input alone releases the lock.

// File: rtl/ddr_pkg.sv
package ddr_pkg;
    localparam int BIT_WP      = 0;
    localparam int BIT_LOCK    = 1;
    localparam int BIT_FDC_DIS = 3;

    typedef struct packed {
        logic wp;
        logic lock;
        logic fdc_dis;
    } ddr_bits_t;
endpackage

// File: rtl/ddr_copy.sv
module ddr_copy
    import ddr_pkg::*;
#(
    parameter int              ADDR_W   = 8,
    parameter int              DATA_W   = 8,
    parameter logic [ADDR_W-1:0] OFFSET = '0,
    parameter bit              LOCKABLE = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output ddr_bits_t         bits_o
);
    ddr_bits_t bits_d, bits_q;
    logic      hit;
    logic      unused_wdata;

    assign unused_wdata = ^wdata;
    assign hit          = (addr == OFFSET);

    always_comb begin
        bits_d = bits_q;
        if (wr_en && hit && !bits_q.lock) begin
            bits_d.wp      = wdata[BIT_WP];
            bits_d.fdc_dis = wdata[BIT_FDC_DIS];
            bits_d.lock    = LOCKABLE ? wdata[BIT_LOCK] : 1'b0;
        end
        rdata = '0;
        if (hit) begin
            rdata[BIT_WP]      = bits_q.wp;
            rdata[BIT_LOCK]    = bits_q.lock;
            rdata[BIT_FDC_DIS] = bits_q.fdc_dis;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) bits_q <= '0;
        else     bits_q <= bits_d;
    end

    assign bits_o = bits_q;

    generate
        if (LOCKABLE) begin : g_lock_chk
            // R5
            lock_freeze_chk: assert property (@(posedge clk) disable iff (rst)
                bits_q.lock |=> $stable(bits_q));
            // R5
            lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
                bits_q.lock |=> bits_q.lock);
        end
    endgenerate
endmodule

// File: rtl/ddr_wp_combine.sv
module ddr_wp_combine #(
    parameter int NUM_SEL = 2
) (
    input  logic               reg_wp_m,
    input  logic               reg_wp_h,
    input  logic               wp_in,
    input  logic [NUM_SEL-1:0] sel,
    input  logic               force_wp,
    output logic               wp_out
);
    logic [NUM_SEL-1:0] sel_terms;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_SEL; gi++) begin : g_sel
            assign sel_terms[gi] = sel[gi] & force_wp;
        end
    endgenerate

    assign wp_out = reg_wp_m | reg_wp_h | wp_in | (|sel_terms);
endmodule

// File: rtl/ddr_dual_disable.sv
module ddr_dual_disable
    import ddr_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter int                DATA_W   = 8,
    parameter int                NUM_SEL  = 2,
    parameter logic [ADDR_W-1:0] MGMT_OFS = 8'h01,
    parameter logic [ADDR_W-1:0] HOST_OFS = 8'h22
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               bus_rst_n,
    input  logic               h_wr_en,
    input  logic [ADDR_W-1:0]  h_addr,
    input  logic [DATA_W-1:0]  h_wdata,
    output logic [DATA_W-1:0]  h_rdata,
    input  logic               m_wr_en,
    input  logic [ADDR_W-1:0]  m_addr,
    input  logic [DATA_W-1:0]  m_wdata,
    output logic [DATA_W-1:0]  m_rdata,
    input  logic               fdc_activate,
    input  logic               drv_wp_in,
    input  logic [NUM_SEL-1:0] drv_sel,
    input  logic               force_wp,
    output logic               fdc_enable,
    output logic               wp_out
);
    typedef struct packed {
        logic fdc_en;
    } out_state_t;

    logic       rst;
    ddr_bits_t  m_bits, h_bits;
    out_state_t out_d, out_q;
    logic       unused_locks;

    assign rst          = ~por_n | ~bus_rst_n;
    assign unused_locks = m_bits.lock ^ h_bits.lock;

    ddr_copy #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFFSET(MGMT_OFS), .LOCKABLE(1'b1)
    ) i_mgmt_copy (
        .clk(clk), .rst(rst), .wr_en(m_wr_en), .addr(m_addr),
        .wdata(m_wdata), .rdata(m_rdata), .bits_o(m_bits)
    );

    ddr_copy #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFFSET(HOST_OFS), .LOCKABLE(1'b0)
    ) i_host_copy (
        .clk(clk), .rst(rst), .wr_en(h_wr_en), .addr(h_addr),
        .wdata(h_wdata), .rdata(h_rdata), .bits_o(h_bits)
    );

    ddr_wp_combine #(.NUM_SEL(NUM_SEL)) i_wp (
        .reg_wp_m(m_bits.wp), .reg_wp_h(h_bits.wp), .wp_in(drv_wp_in),
        .sel(drv_sel), .force_wp(force_wp), .wp_out(wp_out)
    );

    always_comb begin
        out_d        = out_q;
        out_d.fdc_en = fdc_activate & ~(m_bits.fdc_dis | h_bits.fdc_dis);
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= out_d;
    end

    assign fdc_enable = out_q.fdc_en;

    // R6
    host_wr_unlocked_chk: assert property (@(posedge clk) disable iff (rst)
        (h_wr_en && h_addr == HOST_OFS) |=>
            (h_bits.fdc_dis == $past(h_wdata[BIT_FDC_DIS])) &&
            (h_bits.wp == $past(h_wdata[BIT_WP])));
    // R7
    fdc_dis_chk: assert property (@(posedge clk) disable iff (rst)
        (m_bits.fdc_dis || h_bits.fdc_dis || !fdc_activate) |=> !fdc_enable);
    // R8
    wp_source_chk: assert property (@(posedge clk) disable iff (rst)
        (drv_wp_in || m_bits.wp || h_bits.wp || (force_wp && |drv_sel)) |-> wp_out);
endmodule

// File: tb/test_ddr_dual_disable.sv
module test_ddr_dual_disable;
    logic       clk = 1'b0;
    logic       por_n, bus_rst_n;
    logic       h_wr_en, m_wr_en;
    logic [7:0] h_addr, h_wdata, h_rdata, m_addr, m_wdata, m_rdata;
    logic       fdc_activate, drv_wp_in, force_wp;
    logic [1:0] drv_sel;
    logic       fdc_enable, wp_out;
    int         checks = 0;
    int         errors = 0;

    always #2.5 clk = ~clk;

    ddr_dual_disable i_ddr_dual_disable (
        .clk(clk), .por_n(por_n), .bus_rst_n(bus_rst_n),
        .h_wr_en(h_wr_en), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata),
        .m_wr_en(m_wr_en), .m_addr(m_addr), .m_wdata(m_wdata), .m_rdata(m_rdata),
        .fdc_activate(fdc_activate), .drv_wp_in(drv_wp_in), .drv_sel(drv_sel),
        .force_wp(force_wp), .fdc_enable(fdc_enable), .wp_out(wp_out)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic m_write(logic [7:0] a, logic [7:0] d);
        @(negedge clk); m_wr_en = 1'b1; m_addr = a; m_wdata = d;
        @(negedge clk); m_wr_en = 1'b0;
    endtask

    task automatic h_write(logic [7:0] a, logic [7:0] d);
        @(negedge clk); h_wr_en = 1'b1; h_addr = a; h_wdata = d;
        @(negedge clk); h_wr_en = 1'b0;
    endtask

    task automatic m_read(logic [7:0] a, output logic [7:0] d);
        m_addr = a; #1; d = m_rdata;
    endtask

    task automatic h_read(logic [7:0] a, output logic [7:0] d);
        h_addr = a; #1; d = h_rdata;
    endtask

    task automatic pulse_reset(bit use_por);
        @(negedge clk);
        if (use_por) por_n = 1'b0; else bus_rst_n = 1'b0;
        repeat (2) @(negedge clk);
        por_n = 1'b1; bus_rst_n = 1'b1;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        fdc_activate = 1'b1;
        m_read(8'h01, d); check("R1 mgmt reset", d, 8'h00);
        h_read(8'h22, d); check("R1 host reset", d, 8'h00);
        check("R1 wp reset", {7'b0, wp_out}, 8'h00);
        @(negedge clk);
        check("R1 fdc_enable after reset", {7'b0, fdc_enable}, 8'h01);
    endtask

    task automatic t_readback();
        logic [7:0] d;
        m_write(8'h01, 8'hF9);
        m_read(8'h01, d); check("R2 R4 mgmt readback", d, 8'h09);
        m_read(8'h02, d); check("R2 mgmt other offset", d, 8'h00);
        h_write(8'h22, 8'hFF);
        h_read(8'h22, d); check("R3 R4 host readback", d, 8'h09);
        h_read(8'h01, d); check("R3 host other offset", d, 8'h00);
        m_write(8'h01, 8'h00);
        h_write(8'h22, 8'h00);
        m_read(8'h01, d); check("R2 mgmt cleared", d, 8'h00);
    endtask

    task automatic t_fdc_enable();
        fdc_activate = 1'b1;
        m_write(8'h01, 8'h08);
        check("R7 not yet updated", {7'b0, fdc_enable}, 8'h01);
        @(negedge clk);
        check("R7 mgmt disable", {7'b0, fdc_enable}, 8'h00);
        m_write(8'h01, 8'h00);
        h_write(8'h22, 8'h08);
        @(negedge clk);
        check("R7 host disable", {7'b0, fdc_enable}, 8'h00);
        h_write(8'h22, 8'h00);
        @(negedge clk);
        check("R7 both enabled", {7'b0, fdc_enable}, 8'h01);
        fdc_activate = 1'b0;
        @(negedge clk);
        check("R7 activate low", {7'b0, fdc_enable}, 8'h00);
        fdc_activate = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_wp();
        drv_wp_in = 1'b1; #1;
        check("R8 drive wp", {7'b0, wp_out}, 8'h01);
        drv_wp_in = 1'b0; force_wp = 1'b1; drv_sel = 2'b00; #1;
        check("R8 force no select", {7'b0, wp_out}, 8'h00);
        drv_sel = 2'b01; #1;
        check("R8 force sel0", {7'b0, wp_out}, 8'h01);
        drv_sel = 2'b10; #1;
        check("R8 force sel1", {7'b0, wp_out}, 8'h01);
        force_wp = 1'b0; #1;
        check("R8 sel1 no force", {7'b0, wp_out}, 8'h00);
        drv_sel = 2'b00;
        m_write(8'h01, 8'h01); #1;
        check("R8 mgmt override", {7'b0, wp_out}, 8'h01);
        m_write(8'h01, 8'h00);
        h_write(8'h22, 8'h01); #1;
        check("R8 host override", {7'b0, wp_out}, 8'h01);
        h_write(8'h22, 8'h00); #1;
        check("R8 all clear", {7'b0, wp_out}, 8'h00);
    endtask

    task automatic t_lock();
        logic [7:0] d;
        m_write(8'h01, 8'h0A);
        m_read(8'h01, d); check("R5 lock set", d, 8'h0A);
        m_write(8'h01, 8'h01);
        m_read(8'h01, d); check("R5 locked write ignored", d, 8'h0A);
        check("R5 locked wp unchanged", {7'b0, wp_out}, 8'h00);
        h_write(8'h22, 8'h09);
        h_read(8'h22, d); check("R6 host write while locked", d, 8'h09);
        h_write(8'h22, 8'h00);
        h_read(8'h22, d); check("R6 host clear while locked", d, 8'h00);
    endtask

    task automatic t_resets();
        logic [7:0] d;
        h_write(8'h22, 8'h08);
        pulse_reset(1'b0);
        m_read(8'h01, d); check("R9 bus reset mgmt", d, 8'h00);
        h_read(8'h22, d); check("R9 bus reset host", d, 8'h00);
        m_write(8'h01, 8'h01);
        m_read(8'h01, d); check("R9 unlocked after bus reset", d, 8'h01);
        m_write(8'h01, 8'h02);
        pulse_reset(1'b1);
        m_read(8'h01, d); check("R9 por clears lock", d, 8'h00);
        m_write(8'h01, 8'h08);
        m_read(8'h01, d); check("R9 writable after por", d, 8'h08);
    endtask

    initial begin
        #50000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        por_n = 1'b0; bus_rst_n = 1'b0;
        h_wr_en = 1'b0; m_wr_en = 1'b0;
        h_addr = '0; h_wdata = '0; m_addr = '0; m_wdata = '0;
        fdc_activate = 1'b1; drv_wp_in = 1'b0; force_wp = 1'b0; drv_sel = 2'b00;
        repeat (3) @(negedge clk);
        por_n = 1'b1; bus_rst_n = 1'b1;
        t_reset();
        t_readback();
        t_fdc_enable();
        t_wp();
        t_lock();
        t_resets();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule